// File: doc/BRIEF.md
# Serial Hex-Record RAM Loader

This block sits behind a UART receiver and turns a stream of ASCII characters into RAM writes. It skips every character until a colon appears. It then reads one hex record as pairs of hex characters: the length, the 16-bit load address, the record type, the payload bytes and the record checksum. Each payload byte of a data record is written to RAM at its own address. While loading, the transmit side stays silent.

An end record that passes every check closes the load. The block then sends a 16-bit running sum of all written bytes, most significant byte first, through a valid/ready byte interface. After that it raises a jump request that carries the load address of the first data record. A bad character, a wrong checksum, an unknown record type or a receive error stops the block in a halt state. In that state it sends no reply, and only reset ends it.

Top module: `hex_ram_loader`

## Requirements
- R1: Before a colon (3AH) arrives, every received byte is ignored and causes no RAM write, even when it is a hex digit.
- R2: Record fields arrive as pairs of ASCII characters, first character the upper nibble, each from 0-9 (30H-39H) or A-F (41H-46H). Any other character inside a record, lower-case letters included, halts the block.
- R3: Fields are taken in this order: length, address upper byte, address lower byte, type, payload, checksum. The payload byte at offset k of a type-00H record is written to RAM address (address + k) mod 2^16. ram_we is high for exactly one cycle per byte, one cycle after the byte's second character is received.
- R4: The low 8 bits of the sum of every byte of a record, checksum byte included, must be 00H. Otherwise the block halts.
- R5: Only type 00H (data) and 01H (end) are accepted, and an end record must have length 00H. Anything else halts the block.
- R6: A received byte flagged with rx_error halts the block, whatever state the parser is in before the reply starts.
- R7: Once halted, halted stays 1 until reset. tx_valid and ram_we stay 0 and no reply is sent.
- R8: No byte is transmitted while records are being received; tx_valid stays 0 until a valid end record has been accepted.
- R9: After a valid end record, two bytes are offered on tx_data, the upper byte of the sum first. Each byte is held with tx_valid high and unchanged until accepted by tx_ready.
- R10: The reply value is the sum, modulo 65536, of every byte written to RAM since reset.
- R11: Once the second reply byte is accepted, jump_valid stays 1 and jump_addr holds the address field of the first data record accepted (0000H if there was none). Later received bytes change nothing.
- R12: After reset, halted, tx_valid, ram_we and jump_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_error | input | 1 | The received byte had a framing or parity fault |
| tx_valid | output | 1 | Reply byte offered |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_data | output | 8 | Reply byte |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| halted | output | 1 | Sticky error halt |
| jump_valid | output | 1 | Load finished; execution request |
| jump_addr | output | 16 | Requested execution address |

## Verification
The assertions assume that rx_valid lasts one cycle per received byte and that rx_error is read only together with rx_valid. The bench drives each character as a single-cycle pulse with an idle cycle after it, so this assumption holds. The handshake checks also assume the transmitter only raises tx_ready. They do not assume it must ever do so. The bench therefore keeps tx_ready low for several cycles before each acceptance and never drops a byte it has offered. Every record the bench builds is either fully well-formed or carries exactly one deliberate fault, so each halt can be traced to a single cause.

// File: rtl/hexld_pkg.sv
package hexld_pkg;

  localparam logic [7:0] START_MARK = 8'h3A;
  localparam logic [7:0] KIND_DATA  = 8'h00;
  localparam logic [7:0] KIND_END   = 8'h01;

  typedef enum logic [1:0] {
    PS_HUNT,
    PS_FIELD,
    PS_DONE,
    PS_HALT
  } pstate_t;

  typedef enum logic [2:0] {
    FD_LEN,
    FD_ADDR_HI,
    FD_ADDR_LO,
    FD_KIND,
    FD_DATA,
    FD_CSUM
  } field_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_SEND,
    RS_JUMP
  } rstate_t;

endpackage

// File: rtl/hexld_rst_sync.sv
module hexld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hexld_nibble.sv
module hexld_nibble (
  input  logic [7:0] ch,
  output logic [3:0] val,
  output logic       ok
);

  logic [7:0] off;

  always_comb begin
    off = 8'h00;
    ok  = 1'b0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      off = ch - 8'h30;
      ok  = 1'b1;
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      off = ch - 8'h37;
      ok  = 1'b1;
    end
    val = off[3:0];
  end

endmodule

// File: rtl/hexld_parser.sv
module hexld_parser
  import hexld_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_error,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              end_ok,
  output logic              halted,
  output logic [15:0]       entry_addr
);

  pstate_t     state_q, state_d;
  field_t      field_q, field_d;
  logic        phase_q, phase_d;
  logic [3:0]  hi_q, hi_d;
  logic [7:0]  len_q, len_d;
  logic [15:0] addr_q, addr_d;
  logic [7:0]  kind_q, kind_d;
  logic [7:0]  cnt_q, cnt_d;
  logic [7:0]  sum_q, sum_d;
  logic        seen_q, seen_d;
  logic [15:0] entry_q, entry_d;
  logic        we_d, end_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [7:0]  wdata_q, wdata_d;
  logic        we_q, end_q;

  logic [3:0]  nib_val;
  logic        nib_ok;
  logic [7:0]  cur_byte;
  logic [7:0]  sum_next;
  logic [15:0] target;

  hexld_nibble u_nib (
    .ch  (rx_data),
    .val (nib_val),
    .ok  (nib_ok)
  );

  assign cur_byte = {hi_q, nib_val};
  assign sum_next = sum_q + cur_byte;
  assign target   = addr_q + {8'h00, cnt_q};

  always_comb begin
    state_d = state_q;
    field_d = field_q;
    phase_d = phase_q;
    hi_d    = hi_q;
    len_d   = len_q;
    addr_d  = addr_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sum_d   = sum_q;
    seen_d  = seen_q;
    entry_d = entry_q;
    we_d    = 1'b0;
    end_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    case (state_q)
      PS_HUNT: begin
        if (rx_valid) begin
          if (rx_error) begin
            state_d = PS_HALT;
          end else if (rx_data == START_MARK) begin
            state_d = PS_FIELD;
            field_d = FD_LEN;
            phase_d = 1'b0;
            sum_d   = 8'h00;
            cnt_d   = 8'h00;
          end
        end
      end
      PS_FIELD: begin
        if (rx_valid) begin
          if (rx_error || !nib_ok) begin
            state_d = PS_HALT;
          end else if (!phase_q) begin
            hi_d    = nib_val;
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            sum_d   = sum_next;
            case (field_q)
              FD_LEN: begin
                len_d   = cur_byte;
                field_d = FD_ADDR_HI;
              end
              FD_ADDR_HI: begin
                addr_d[15:8] = cur_byte;
                field_d      = FD_ADDR_LO;
              end
              FD_ADDR_LO: begin
                addr_d[7:0] = cur_byte;
                field_d     = FD_KIND;
              end
              FD_KIND: begin
                kind_d = cur_byte;
                cnt_d  = 8'h00;
                if (cur_byte != KIND_DATA && cur_byte != KIND_END)
                  state_d = PS_HALT;
                else if (cur_byte == KIND_END && len_q != 8'h00)
                  state_d = PS_HALT;
                else if (len_q == 8'h00)
                  field_d = FD_CSUM;
                else
                  field_d = FD_DATA;
              end
              FD_DATA: begin
                we_d    = 1'b1;
                waddr_d = target[ADDR_W-1:0];
                wdata_d = cur_byte;
                cnt_d   = cnt_q + 8'h01;
                if (cnt_q == len_q - 8'h01) field_d = FD_CSUM;
              end
              FD_CSUM: begin
                if (sum_next != 8'h00) begin
                  state_d = PS_HALT;
                end else if (kind_q == KIND_END) begin
                  state_d = PS_DONE;
                  end_d   = 1'b1;
                end else begin
                  state_d = PS_HUNT;
                  if (!seen_q) begin
                    seen_d  = 1'b1;
                    entry_d = addr_q;
                  end
                end
              end
              default: state_d = PS_HALT;
            endcase
          end
        end
      end
      PS_DONE: state_d = PS_DONE;
      default: state_d = PS_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_HUNT;
      field_q <= FD_LEN;
      phase_q <= 1'b0;
      hi_q    <= 4'h0;
      len_q   <= 8'h00;
      addr_q  <= 16'h0000;
      kind_q  <= 8'h00;
      cnt_q   <= 8'h00;
      sum_q   <= 8'h00;
      seen_q  <= 1'b0;
      entry_q <= 16'h0000;
      we_q    <= 1'b0;
      end_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= 8'h00;
    end else begin
      state_q <= state_d;
      field_q <= field_d;
      phase_q <= phase_d;
      hi_q    <= hi_d;
      len_q   <= len_d;
      addr_q  <= addr_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      seen_q  <= seen_d;
      entry_q <= entry_d;
      we_q    <= we_d;
      end_q   <= end_d;
      if (we_d) begin
        waddr_q <= waddr_d;
        wdata_q <= wdata_d;
      end
    end
  end

  assign ram_we     = we_q;
  assign ram_addr   = waddr_q;
  assign ram_wdata  = wdata_q;
  assign end_ok     = end_q;
  assign halted     = (state_q == PS_HALT);
  assign entry_addr = entry_q;

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_no_write_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !ram_we);

  assert_end_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    end_ok |=> !end_ok && !ram_we && !halted);

  assert_reject_bad_char_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_FIELD && rx_valid && !nib_ok) |=> halted);

endmodule

// File: rtl/hexld_reply.sv
module hexld_reply
  import hexld_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             end_ok,
  input  logic [15:0]      entry_addr,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             jump_valid,
  output logic [15:0]      jump_addr
);

  localparam int NBYTES = SUM_W / 8;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  rstate_t          st_q, st_d;
  logic [SUM_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] shr_q, shr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [15:0]      jaddr_q, jaddr_d;

  always_comb begin
    st_d    = st_q;
    acc_d   = acc_q;
    shr_d   = shr_q;
    left_d  = left_q;
    jaddr_d = jaddr_q;
    if (wr_en) acc_d = acc_q + {{(SUM_W-8){1'b0}}, wr_data};
    case (st_q)
      RS_IDLE: begin
        if (end_ok) begin
          st_d    = RS_SEND;
          shr_d   = acc_q;
          left_d  = CNT_W'(NBYTES);
          jaddr_d = entry_addr;
        end
      end
      RS_SEND: begin
        if (tx_ready) begin
          shr_d  = shr_q << 8;
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_d = RS_JUMP;
        end
      end
      default: st_d = RS_JUMP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_IDLE;
      acc_q   <= '0;
      shr_q   <= '0;
      left_q  <= '0;
      jaddr_q <= 16'h0000;
    end else begin
      st_q    <= st_d;
      acc_q   <= acc_d;
      shr_q   <= shr_d;
      left_q  <= left_d;
      jaddr_q <= jaddr_d;
    end
  end

  assign tx_valid   = (st_q == RS_SEND);
  assign tx_data    = shr_q[SUM_W-1 -: 8];
  assign jump_valid = (st_q == RS_JUMP);
  assign jump_addr  = jaddr_q;

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_tx_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(end_ok));

  assert_jump_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> (jump_valid && $stable(jump_addr) && !tx_valid));

endmodule

// File: rtl/hex_ram_loader.sv
module hex_ram_loader #(
  parameter int ADDR_W = 16,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_error,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              halted,
  output logic              jump_valid,
  output logic [15:0]       jump_addr
);

  logic        rst_n_s;
  logic        end_ok;
  logic [15:0] entry_addr;

  hexld_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  hexld_parser #(.ADDR_W(ADDR_W)) u_parse (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_error   (rx_error),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .end_ok     (end_ok),
    .halted     (halted),
    .entry_addr (entry_addr)
  );

  hexld_reply #(.SUM_W(SUM_W)) u_reply (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (ram_we),
    .wr_data    (ram_wdata),
    .end_ok     (end_ok),
    .entry_addr (entry_addr),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .jump_valid (jump_valid),
    .jump_addr  (jump_addr)
  );

  assert_silent_halt_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    halted |-> (!tx_valid && !jump_valid));

  assert_rx_error_halts_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_valid && rx_error && !end_ok && !tx_valid && !jump_valid) |=> halted);

endmodule

// File: tb/sim_hex_ram_loader.sv
module sim_hex_ram_loader;

  logic        clk;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_error;
  logic        tx_valid;
  logic        tx_ready;
  logic [7:0]  tx_data;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        halted;
  logic        jump_valid;
  logic [15:0] jump_addr;

  int checks;
  int fails;

  logic [7:0] model_mem [int];
  int         wr_count;
  int         tx_cycles;

  localparam int NEXP = 5;
  localparam logic [23:0] EXP_MEM [NEXP] = '{
    24'h0010_11, 24'h0011_22, 24'h0012_33, 24'h0020_AA, 24'h0021_BB
  };

  hex_ram_loader u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_error   (rx_error),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .halted     (halted),
    .jump_valid (jump_valid),
    .jump_addr  (jump_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      model_mem[int'(ram_addr)] = ram_wdata;
      wr_count++;
    end
    if (rst_n && tx_valid) tx_cycles++;
  end

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    rx_valid = 1'b0;
    rx_data  = 8'h00;
    rx_error = 1'b0;
    tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_mem.delete();
    wr_count  = 0;
    tx_cycles = 0;
  endtask

  task automatic send_ch(input logic [7:0] c, input bit err = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = c;
    rx_error = err;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_error = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_ch(s[i]);
  endtask

  function automatic logic [7:0] nib_ch(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  task automatic send_hex(input logic [7:0] b);
    send_ch(nib_ch(b[7:4]));
    send_ch(nib_ch(b[3:0]));
  endtask

  task automatic send_fill_record(input logic [15:0] a, input logic [7:0] n, input logic [7:0] v);
    logic [7:0] s;
    s = n + a[15:8] + a[7:0];
    send_ch(8'h3A);
    send_hex(n);
    send_hex(a[15:8]);
    send_hex(a[7:0]);
    send_hex(8'h00);
    for (int i = 0; i < n; i++) begin
      send_hex(v);
      s = s + v;
    end
    send_hex(8'h00 - s);
  endtask

  task automatic take_byte(output logic [7:0] b, output bit got);
    got = 1'b0;
    b   = 8'h00;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      if (tx_valid) begin
        repeat (3) @(negedge clk);
        b = tx_data;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        got = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b0;
    logic [7:0] b1;
    bit g0;
    bit g1;
    checks = 0;
    fails  = 0;

    // R12: reset state
    do_reset();
    check(!halted && !tx_valid && !ram_we && !jump_valid, "R12 reset outputs",
          {halted, tx_valid, ram_we, jump_valid}, 0);

    // Main load: leading hex-looking garbage (R1), two data records, end record
    send_str("0300zz");
    send_str(":03001000112233");
    send_str("87\r\n");
    send_str(":02002000AABB79\r\n");
    repeat (4) @(negedge clk);
    check(wr_count == NEXP, "R1 R3 write count", wr_count, NEXP);
    for (int i = 0; i < NEXP; i++) begin
      int a;
      a = int'(EXP_MEM[i][23:8]);
      check(model_mem.exists(a) && model_mem[a] == EXP_MEM[i][7:0], "R3 ram content",
            model_mem.exists(a) ? int'(model_mem[a]) : -1, int'(EXP_MEM[i][7:0]));
    end
    check(tx_cycles == 0, "R8 no echo while loading", tx_cycles, 0);
    check(!halted, "R8 clean load not halted", halted, 0);

    send_str(":00000001FF");
    repeat (2) @(negedge clk);
    check(tx_valid && tx_data == 8'h01, "R9 upper byte offered first", tx_data, 8'h01);
    repeat (5) @(negedge clk);
    check(tx_valid && tx_data == 8'h01, "R9 byte held without ready", tx_data, 8'h01);
    take_byte(b0, g0);
    take_byte(b1, g1);
    check(g0 && b0 == 8'h01, "R10 sum upper", b0, 8'h01);
    check(g1 && b1 == 8'hCB, "R10 sum lower", b1, 8'hCB);
    @(negedge clk);
    check(jump_valid && jump_addr == 16'h0010, "R11 jump to first record", jump_addr, 16'h0010);
    send_str(":0100400077");
    send_str("48");
    repeat (3) @(negedge clk);
    check(wr_count == NEXP && jump_valid && !tx_valid && jump_addr == 16'h0010,
          "R11 input ignored after load", wr_count, NEXP);

    // R4: bad record checksum halts, then no reply even for an end record (R7)
    do_reset();
    send_str(":010030005500");
    repeat (2) @(negedge clk);
    check(halted, "R4 checksum mismatch halts", halted, 1);
    send_str(":00000001FF");
    repeat (8) @(negedge clk);
    check(halted && tx_cycles == 0 && !jump_valid, "R7 halt is silent and sticky", tx_cycles, 0);

    // R2: non-hex character
    do_reset();
    send_str(":01G");
    repeat (2) @(negedge clk);
    check(halted, "R2 non-hex halts", halted, 1);

    // R2: lower-case hex digit
    do_reset();
    send_str(":0a");
    repeat (2) @(negedge clk);
    check(halted, "R2 lower-case halts", halted, 1);

    // R5: unknown record type
    do_reset();
    send_str(":0000000200");
    repeat (2) @(negedge clk);
    check(halted && wr_count == 0, "R5 type 02 halts", halted, 1);

    // R5: end record with non-zero length
    do_reset();
    send_str(":0100000100FE");
    repeat (8) @(negedge clk);
    check(halted && tx_cycles == 0, "R5 end record with length halts", halted, 1);

    // R6: receive error in the middle of a record
    do_reset();
    send_str(":01");
    send_ch(8'h30, 1'b1);
    repeat (2) @(negedge clk);
    check(halted, "R6 receive error halts", halted, 1);

    // R6: receive error while hunting
    do_reset();
    send_ch(8'h41, 1'b1);
    repeat (2) @(negedge clk);
    check(halted, "R6 receive error while hunting halts", halted, 1);

    // R10: sum wraps modulo 65536; R11 first record address kept
    do_reset();
    send_fill_record(16'h0100, 8'hFF, 8'hFF);
    send_fill_record(16'h0200, 8'hFF, 8'hFF);
    send_str(":00000001FF");
    take_byte(b0, g0);
    take_byte(b1, g1);
    check(g0 && g1 && {b0, b1} == 16'hFC02, "R10 sum wraps", {b0, b1}, 16'hFC02);
    check(wr_count == 510, "R3 long record write count", wr_count, 510);
    @(negedge clk);
    check(jump_valid && jump_addr == 16'h0100, "R11 first of two records", jump_addr, 16'h0100);

    // R11: end record alone gives zero sum and zero address
    do_reset();
    send_str(":00000001FF");
    take_byte(b0, g0);
    take_byte(b1, g1);
    @(negedge clk);
    check(g0 && g1 && {b0, b1} == 16'h0000, "R10 empty load sum", {b0, b1}, 0);
    check(jump_valid && jump_addr == 16'h0000, "R11 no data record address", jump_addr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule